// File: doc/BRIEF.md
# Transceiver Interrupt Mask and Pending Unit

This block gathers the interrupt events of a radio transceiver and turns them into per-source interrupt requests for a CPU interrupt unit. Eight event sources feed it, each as a pulse one clock wide: PLL lock, PLL unlock, receive start, receive end, energy-detect/channel-assessment done, address match, transmit end and awake. Every pulse is recorded in a pending register. Each source also has a bit in an enable register. A source raises its request line only while its pending bit and its enable bit are both set.

Software reaches both registers over a small register bus. A one-bit select picks the register, and there is a write strobe, write data and read data that follows the select without delay. A pending bit is recorded even while its source is disabled. Because of this, software reads the pending register and clears it before it enables a source, and any old events are removed that way. A pending bit clears in two ways. Software can write a one to it. It also clears by itself when the CPU signals, through a per-source acknowledge input, that the service routine for that source has started. A new event in the same cycle as a clear always wins, so no event is lost.

Top module: `xcvr_irq_ctrl`

## Requirements
- R1: Synchronous active-high reset clears both the enable and the pending register to zero, so every request line is low after reset.
- R2: A write with bus_sel=0 loads bus_wdata into the enable register at the clock edge, and bus_rdata shows the enable register whenever bus_sel=0.
- R3: An event pulse on src_evt[i] sets pending bit i at the next clock edge, whatever the value of enable bit i. The bit positions are 7 awake, 6 transmit end, 5 address match, 4 energy-detect/assessment done, 3 receive end, 2 receive start, 1 PLL unlock, 0 PLL lock. bus_rdata shows the pending register whenever bus_sel=1.
- R4: A write with bus_sel=1 clears every pending bit whose bus_wdata bit is 1, and leaves every pending bit whose bus_wdata bit is 0 unchanged.
- R5: src_ack[i] held high at a clock edge clears pending bit i.
- R6: When an event and a clear (write-one or acknowledge) reach the same pending bit at the same edge, the bit ends up set.
- R7: irq_req[i] is 1 exactly when pending bit i and enable bit i are both 1.
- R8: A write to one register leaves the other register unchanged. With no event, no acknowledge and no pending write, the pending register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | 8 | One-cycle event pulses, one per source |
| src_ack | input | 8 | Per-source service-entry acknowledge |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 enable, 1 pending |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| irq_req | output | 8 | Per-source interrupt requests |

## Verification
Events, acknowledges and register writes take effect at the first clock edge after they are applied. The new register contents and the request lines that follow from them can be seen straight after that edge, and the read data already follows the select in the same cycle. The bench drives all inputs at the falling edge and advances a model of both registers at the rising edge. Shortly after the rising edge it compares the request lines, then switches the select to read back each register in turn, and all of this finishes before the next falling edge. Directed sweeps go over each bit for masked latching, write-one clear, acknowledge clear and collisions, and a pseudo-random phase then mixes all input kinds together.

// File: rtl/xcvr_irq_pkg.sv
package xcvr_irq_pkg;

   localparam int SRC_COUNT = 8;

   // Source bit positions; software and the CPU interrupt unit decode these.
   localparam int POS_PLL_LOCK   = 0;
   localparam int POS_PLL_UNLOCK = 1;
   localparam int POS_RX_START   = 2;
   localparam int POS_RX_END     = 3;
   localparam int POS_ED_DONE    = 4;
   localparam int POS_ADDR_MATCH = 5;
   localparam int POS_TX_END     = 6;
   localparam int POS_AWAKE      = 7;

   // Register select values on bus_sel
   typedef enum logic {
      SEL_ENABLE  = 1'b0,
      SEL_PENDING = 1'b1
   } reg_sel_e;

   // Next value of one pending bit under a chosen priority rule.
   function automatic logic pend_next(input logic cur, input logic set,
                                      input logic clr, input logic set_wins);
      logic nxt;
      if (set_wins) nxt = set | (cur & ~clr);
      else          nxt = ~clr & (set | cur);
      return nxt;
   endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
   import xcvr_irq_pkg::*;
#(
   parameter int NUM_SRC = SRC_COUNT
) (
   input  logic               bus_wr,
   input  logic               bus_sel,
   input  logic [NUM_SRC-1:0] bus_wdata,
   input  logic [NUM_SRC-1:0] src_ack,
   input  logic [NUM_SRC-1:0] en_val,
   input  logic [NUM_SRC-1:0] pend_val,
   output logic               en_load,
   output logic [NUM_SRC-1:0] pend_clr,
   output logic [NUM_SRC-1:0] bus_rdata
);

   logic pend_write;

   always_comb begin
      en_load    = bus_wr && (reg_sel_e'(bus_sel) == SEL_ENABLE);
      pend_write = bus_wr && (reg_sel_e'(bus_sel) == SEL_PENDING);
      pend_clr   = src_ack | (pend_write ? bus_wdata : '0);
      bus_rdata  = (reg_sel_e'(bus_sel) == SEL_PENDING) ? pend_val : en_val;
   end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= din;
   end

endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
   import xcvr_irq_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);

   logic d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb d = pend_next(q, set, clr, 1'b1);
      end else begin : g_clr_first
         always_comb d = pend_next(q, set, clr, 1'b0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
   end

endmodule

// File: rtl/xcvr_irq_ctrl.sv
module xcvr_irq_ctrl
   import xcvr_irq_pkg::*;
#(
   parameter int NUM_SRC  = SRC_COUNT,
   parameter bit SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic [NUM_SRC-1:0] src_ack,
   input  logic               bus_wr,
   input  logic               bus_sel,
   input  logic [NUM_SRC-1:0] bus_wdata,
   output logic [NUM_SRC-1:0] bus_rdata,
   output logic [NUM_SRC-1:0] irq_req
);

   localparam int MAX_SRC = 32;

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_count
         $error("xcvr_irq_ctrl: NUM_SRC out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] stat_q;
   logic [NUM_SRC-1:0] pend_clr;
   logic               en_load;

   irq_bus_decode #(.NUM_SRC(NUM_SRC)) u_dec (
      .bus_wr   (bus_wr),
      .bus_sel  (bus_sel),
      .bus_wdata(bus_wdata),
      .src_ack  (src_ack),
      .en_val   (en_q),
      .pend_val (stat_q),
      .en_load  (en_load),
      .pend_clr (pend_clr),
      .bus_rdata(bus_rdata)
   );

   irq_mask_reg #(.WIDTH(NUM_SRC)) u_en (
      .clk (clk),
      .rst (rst),
      .load(en_load),
      .din (bus_wdata),
      .q   (en_q)
   );

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         irq_pend_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk(clk),
            .rst(rst),
            .set(src_evt[i]),
            .clr(pend_clr[i]),
            .q  (stat_q[i])
         );
         assign irq_req[i] = stat_q[i] & en_q[i];
      end
   endgenerate

endmodule

// File: rtl/xcvr_irq_chk.sv
module xcvr_irq_chk #(
   parameter int NUM_SRC = 8
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_SRC-1:0] src_evt,
   input logic [NUM_SRC-1:0] src_ack,
   input logic               bus_wr,
   input logic               bus_sel,
   input logic [NUM_SRC-1:0] bus_wdata,
   input logic [NUM_SRC-1:0] irq_req,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] stat_q
);

   logic [NUM_SRC-1:0] clr_any;
   always_comb clr_any = src_ack | ((bus_wr && bus_sel) ? bus_wdata : '0);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (en_q == '0 && stat_q == '0)); // R1

   AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !bus_sel) |=> en_q == $past(bus_wdata)); // R2

   AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (rst)
      (src_evt != '0) |=> ((stat_q & $past(src_evt)) == $past(src_evt))); // R3

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      ((clr_any & ~src_evt) != '0) |=> ((stat_q & $past(clr_any & ~src_evt)) == '0)); // R4

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
      (irq_req & ~en_q) == '0); // R7

   AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
      (irq_req & ~stat_q) == '0); // R7

   AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && !bus_sel) |=> $stable(en_q)); // R8

   AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (src_evt == '0 && clr_any == '0) |=> $stable(stat_q)); // R8

endmodule

bind xcvr_irq_ctrl xcvr_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .src_evt  (src_evt),
   .src_ack  (src_ack),
   .bus_wr   (bus_wr),
   .bus_sel  (bus_sel),
   .bus_wdata(bus_wdata),
   .irq_req  (irq_req),
   .en_q     (en_q),
   .stat_q   (stat_q)
);

// File: tb/tb_xcvr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_xcvr_irq_ctrl;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [N-1:0] src_evt, src_ack, bus_wdata, bus_rdata, irq_req;
   logic         bus_wr, bus_sel;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [N-1:0] m_en, m_st;
   logic [15:0]  lfsr;

   always #2.5 clk = ~clk;

   xcvr_irq_ctrl dut (
      .clk(clk), .rst(rst), .src_evt(src_evt), .src_ack(src_ack),
      .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_req(irq_req)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: drive at falling edge, model at rising edge, check after it.
   task automatic cyc(input logic [N-1:0] evt, input logic [N-1:0] ack,
                      input logic wr, input logic sel, input logic [N-1:0] wd,
                      input string req);
      logic [N-1:0] clr;
      @(negedge clk);
      src_evt = evt; src_ack = ack; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
      @(posedge clk);
      clr  = ack | ((wr && sel) ? wd : '0);
      m_st = (m_st & ~clr) | evt;              // R6: set wins
      if (wr && !sel) m_en = wd;
      #1;
      src_evt = '0; src_ack = '0; bus_wr = 1'b0; bus_wdata = '0;
      chk({req, "/R7 irq"}, irq_req, m_st & m_en);
      bus_sel = 1'b0; #0.4;
      chk({req, "/R2 enable readback"}, bus_rdata, m_en);
      bus_sel = 1'b1; #0.4;
      chk({req, "/R3 pending readback"}, bus_rdata, m_st);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; src_evt = '0; src_ack = '0; bus_wr = 0; bus_sel = 0; bus_wdata = '0;
      m_en = '0; m_st = '0; lfsr = 16'hACE1;
      // Dirty the registers before a second reset
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      cyc('0, '0, 1'b1, 1'b0, 8'hFF, "R2 pre");
      cyc(8'h5A, '0, 1'b0, 1'b0, '0, "R3 pre");
      @(negedge clk); rst = 1'b1;
      @(posedge clk); m_en = '0; m_st = '0;
      @(negedge clk); rst = 1'b0;
      bus_sel = 1'b0; #0.4; chk("R1 enable after reset", bus_rdata, '0);
      bus_sel = 1'b1; #0.4; chk("R1 pending after reset", bus_rdata, '0);
      chk("R1 irq after reset", irq_req, '0);

      // Masked latching on each bit (awake = bit 7 ... PLL lock = bit 0)
      for (int i = 0; i < N; i++) begin
         cyc(8'(1 << i), '0, 1'b0, 1'b0, '0, "R3 masked latch");
         chk("R3 masked no irq", irq_req, '0);
      end
      // Enable one source at a time: request follows pending & enable
      for (int i = 0; i < N; i++)
         cyc('0, '0, 1'b1, 1'b0, 8'(1 << i), "R7 single enable");
      cyc('0, '0, 1'b1, 1'b0, 8'hFF, "R8 enable write keeps pending");
      // Write-one clear with zeros elsewhere
      cyc('0, '0, 1'b1, 1'b1, 8'h81, "R4 clear ends");
      cyc('0, '0, 1'b1, 1'b1, 8'h00, "R4 zero write no effect");
      cyc('0, '0, 1'b1, 1'b1, 8'h24, "R8 pending write keeps enable");
      // Acknowledge clears
      for (int i = 0; i < N; i++)
         cyc(8'(1 << i), '0, 1'b0, 1'b0, '0, "R3 refill");
      for (int i = 0; i < N; i++)
         cyc('0, 8'(1 << i), 1'b0, 1'b0, '0, "R5 ack clear");
      // Collisions per bit: event with write-one, then event with ack
      for (int i = 0; i < N; i++) begin
         cyc(8'(1 << i), '0, 1'b1, 1'b1, 8'hFF, "R6 event vs write-one");
         cyc(8'(1 << i), 8'(1 << i), 1'b0, 1'b0, '0, "R6 event vs ack");
         cyc('0, 8'(1 << i), 1'b0, 1'b0, '0, "R5 ack after collision");
      end
      // Idle hold
      cyc(8'h3C, '0, 1'b0, 1'b0, '0, "R3 fill");
      cyc('0, '0, 1'b0, 1'b1, '0, "R8 idle hold");
      // Pseudo-random mix
      for (int k = 0; k < 400; k++) begin
         logic [N-1:0] e, a, w;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         e = lfsr[7:0] & lfsr[15:8];
         a = lfsr[15:8] & ~lfsr[3:0];
         w = lfsr[11:4];
         cyc(e, a, lfsr[2], lfsr[9], w, "R6 random mix");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule